// File: doc/BRIEF.md
# Radix-4 Twiddled Butterfly

This block is the arithmetic core of one pass of a 16-point transform built from radix-4 stages. Each accepted beat carries four complex samples with 16-bit two's-complement real and imaginary parts, plus a two-bit group index. The block multiplies the sample in lane p by the twiddle W16^k, where W16 = e^(-j2π/16) and k = group × p (mod 16). The twiddle table is held inside the block. The four rotated samples are then combined by a four-point DFT that needs only sign changes and real/imaginary swaps.

The design is a fixed three-register pipeline. Every beat produces exactly one result beat. Results saturate to the 16-bit range. Any saturation, whether in a twiddle product or in the final sums, sets a single overflow flag that stays set until reset. The surrounding sequencer supplies samples already reordered for the pass and feeds one beat per cycle or leaves gaps.

Top module: `radix4_twiddle_bfly`

## Requirements
- R1: With `rst` high at a rising edge of `clk`, the block clears `out_vld`, `ovfl` and both output buses to zero from the next cycle on. A beat still in flight when reset arrives never appears at the output.
- R2: A beat accepted with `in_vld` high at a rising edge produces `out_vld` high exactly three rising edges later. There is one output beat per input beat, and back-to-back beats are supported.
- R3: Lane p is multiplied by the twiddle with k = (`in_grp` × p) mod 16. The twiddle is stored as real part round(32768·cos(2πk/16)) and imaginary part round(−32768·sin(2πk/16)), in a 17-bit signed form, so ±1.0 is exact and group 0 passes every lane through unchanged.
- R4: Each twiddle product is computed as real = (xr·wr − xi·wi + 2^14) >> 15 and imaginary = (xr·wi + xi·wr + 2^14) >> 15, using an arithmetic shift. A result outside [−32768, 32767] is clamped to the nearest limit and counts as an overflow.
- R5: For rotated samples b0..b3, the outputs are Y0 = b0+b1+b2+b3, Y1 = b0 − j·b1 − b2 + j·b3, Y2 = b0 − b1 + b2 − b3 and Y3 = b0 + j·b1 − b2 − j·b3. These are computed at full precision before saturation.
- R6: Each real or imaginary sum from R5 that falls outside [−32768, 32767] is clamped to the nearest limit and counts as an overflow.
- R7: `ovfl` rises in the same cycle as `out_vld` for the first beat with any overflow under R4 or R6. It then stays high until reset.
- R8: While `in_vld` is low, `in_re`, `in_im` and `in_grp` have no effect. While `out_vld` is low, the output buses and `ovfl` hold their previous values.
- R9: Lane p of `in_re`, `in_im`, `out_re` and `out_im` occupies bits [16p+15 : 16p]. Output lane q carries Yq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input beat strobe |
| in_grp | input | 2 | Group index selecting twiddles |
| in_re | input | 64 | Real parts of four input lanes |
| in_im | input | 64 | Imaginary parts of four input lanes |
| out_vld | output | 1 | Output beat strobe |
| out_re | output | 64 | Real parts of four results |
| out_im | output | 64 | Imaginary parts of four results |
| ovfl | output | 1 | Sticky overflow flag |

## Verification
The embedded properties assume that `rst` is a known value at every edge and that `in_vld` is never unknown once reset is released. They also assume that reset is held for at least one edge before the first beat. The stimulus drives every input only on falling edges and holds reset for several cycles at start-up. Random wide values are placed on the data and group inputs only while `in_vld` is low, which exercises the ignore rule without breaking those assumptions. All four group values, including the pass-through group, appear with both small operands and full-scale operands chosen to force overflow in products and in sums.

// File: rtl/radix4_twiddle_bfly.sv
`timescale 1ns/1ps
module radix4_twiddle_bfly #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [1:0]      in_grp,
  input  logic [4*DW-1:0] in_re,
  input  logic [4*DW-1:0] in_im,
  output logic            out_vld,
  output logic [4*DW-1:0] out_re,
  output logic [4*DW-1:0] out_im,
  output logic            ovfl
);
  localparam int LN = 4;
  localparam int WW = DW + 1;
  localparam int AW = DW + WW + 1;
  localparam int FR = DW - 1;
  localparam longint ONE_L = longint'(1) << FR;
  localparam logic signed [WW-1:0] M0 = WW'(ONE_L);
  localparam logic signed [WW-1:0] M1 = WW'((longint'(30274) * ONE_L) / 32768);
  localparam logic signed [WW-1:0] M2 = WW'((longint'(23170) * ONE_L) / 32768);
  localparam logic signed [WW-1:0] M3 = WW'((longint'(12540) * ONE_L) / 32768);
  localparam logic signed [AW-1:0] RND  = AW'(ONE_L >> 1);
  localparam logic signed [AW-1:0] MAXV = AW'(ONE_L - 1);
  localparam logic signed [AW-1:0] MINV = AW'(-ONE_L);

  function automatic logic signed [WW-1:0] cosq(input logic [3:0] k);
    logic [2:0] idx;
    logic signed [WW-1:0] m;
    case (k[3:2])
      2'd0:    idx = {1'b0, k[1:0]};
      2'd1:    idx = 3'(8 - k);
      2'd2:    idx = {1'b0, k[1:0]};
      default: idx = 3'(16 - k);
    endcase
    case (idx)
      3'd0:    m = M0;
      3'd1:    m = M1;
      3'd2:    m = M2;
      3'd3:    m = M3;
      default: m = '0;
    endcase
    return (k[3:2] == 2'd1 || k[3:2] == 2'd2) ? -m : m;
  endfunction

  function automatic logic fits(input logic signed [AW-1:0] v);
    return (v <= MAXV) && (v >= MINV);
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  // stage 1: capture and twiddle lookup
  logic [3:0] kt [LN];
  always_comb
    for (int p = 0; p < LN; p++) kt[p] = {2'b00, in_grp} * 4'(p);

  logic                   v1;
  logic signed [DW-1:0]   x1r [LN], x1i [LN];
  logic signed [WW-1:0]   w1r [LN], w1i [LN];
  always_ff @(posedge clk) begin
    v1 <= rst ? 1'b0 : in_vld;
    if (in_vld)
      for (int p = 0; p < LN; p++) begin
        x1r[p] <= in_re[p*DW +: DW];
        x1i[p] <= in_im[p*DW +: DW];
        w1r[p] <= cosq(kt[p]);
        w1i[p] <= -cosq(kt[p] - 4'd4);
      end
  end

  // stage 2: complex multiply, round, saturate
  logic signed [AW-1:0] pr [LN], pi [LN];
  logic                 m_ov;
  always_comb begin
    m_ov = 1'b0;
    for (int p = 0; p < LN; p++) begin
      pr[p] = ((AW'(x1r[p]) * AW'(w1r[p])) - (AW'(x1i[p]) * AW'(w1i[p])) + RND) >>> FR;
      pi[p] = ((AW'(x1r[p]) * AW'(w1i[p])) + (AW'(x1i[p]) * AW'(w1r[p])) + RND) >>> FR;
      m_ov  = m_ov | !fits(pr[p]) | !fits(pi[p]);
    end
  end

  logic                 v2, ov2;
  logic signed [DW-1:0] b2r [LN], b2i [LN];
  always_ff @(posedge clk) begin
    v2 <= rst ? 1'b0 : v1;
    if (v1) begin
      ov2 <= m_ov;
      for (int p = 0; p < LN; p++) begin
        b2r[p] <= clamp(pr[p]);
        b2i[p] <= clamp(pi[p]);
      end
    end
  end

  // stage 3: four-point combine with trivial rotations
  logic signed [AW-1:0] er [LN], ei [LN], sr [LN], si [LN];
  logic                 a_ov;
  always_comb begin
    for (int p = 0; p < LN; p++) begin
      er[p] = AW'(b2r[p]);
      ei[p] = AW'(b2i[p]);
    end
    sr[0] = er[0] + er[1] + er[2] + er[3];
    si[0] = ei[0] + ei[1] + ei[2] + ei[3];
    sr[1] = er[0] + ei[1] - er[2] - ei[3];
    si[1] = ei[0] - er[1] - ei[2] + er[3];
    sr[2] = er[0] - er[1] + er[2] - er[3];
    si[2] = ei[0] - ei[1] + ei[2] - ei[3];
    sr[3] = er[0] - ei[1] - er[2] + ei[3];
    si[3] = ei[0] + er[1] - ei[2] - er[3];
    a_ov = 1'b0;
    for (int q = 0; q < LN; q++) a_ov = a_ov | !fits(sr[q]) | !fits(si[q]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      ovfl    <= 1'b0;
      out_re  <= '0;
      out_im  <= '0;
    end else begin
      out_vld <= v2;
      if (v2) begin
        ovfl <= ovfl | ov2 | a_ov;
        for (int q = 0; q < LN; q++) begin
          out_re[q*DW +: DW] <= clamp(sr[q]);
          out_im[q*DW +: DW] <= clamp(si[q]);
        end
      end
    end
  end

  // cycles since reset, saturating; used only by the properties below
  logic [1:0] age;
  always_ff @(posedge clk)
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_vld && !ovfl)); // R1
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R2
  AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(ovfl)) |-> ovfl); // R7
  AST_OVFL_WITH_BEAT: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $rose(ovfl)) |-> out_vld); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_vld) |-> ($stable(out_re) && $stable(out_im))); // R8
endmodule

// File: tb/radix4_twiddle_bfly_tb.sv
`timescale 1ns/1ps
module radix4_twiddle_bfly_tb;
  localparam int NV = 512;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0, rst = 1'b1, in_vld = 1'b0;
  logic [1:0]  in_grp = '0;
  logic [63:0] in_re = '0, in_im = '0;
  logic        out_vld, ovfl;
  logic [63:0] out_re, out_im;

  radix4_twiddle_bfly u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_grp(in_grp),
    .in_re(in_re), .in_im(in_im),
    .out_vld(out_vld), .out_re(out_re), .out_im(out_im), .ovfl(ovfl)
  );

  always #2.5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_re [NV], exp_im [NV];
  bit          exp_ov [NV];
  longint      exp_cyc [NV];
  string       exp_tag [NV];
  int  wr_i = 0, rd_i = 0;
  bit  sticky = 0;
  longint xr [4], xi [4];

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  function automatic longint clampv(input longint v, inout bit ov);
    if (v > 32767)  begin ov = 1'b1; return 32767;  end
    if (v < -32768) begin ov = 1'b1; return -32768; end
    return v;
  endfunction

  task automatic push(input int g, input string tag);
    longint br [4], bi [4];
    longint wr, wi, pr, pq, sr, si;
    bit ov;
    real ang;
    logic [63:0] er, ei, dr, di;
    ov = 1'b0;
    for (int p = 0; p < 4; p++) begin
      ang = 2.0 * PI * real'((g * p) % 16) / 16.0;
      wr  = longint'($rtoi($floor($cos(ang) * 32768.0 + 0.5)));
      wi  = longint'($rtoi($floor(-$sin(ang) * 32768.0 + 0.5)));
      pr  = xr[p] * wr - xi[p] * wi + 16384;
      pq  = xr[p] * wi + xi[p] * wr + 16384;
      br[p] = clampv(pr >>> 15, ov);
      bi[p] = clampv(pq >>> 15, ov);
    end
    for (int q = 0; q < 4; q++) begin
      sr = 0; si = 0;
      for (int p = 0; p < 4; p++)
        case ((p * q) % 4)
          0: begin sr += br[p]; si += bi[p]; end
          1: begin sr += bi[p]; si -= br[p]; end
          2: begin sr -= br[p]; si -= bi[p]; end
          default: begin sr -= bi[p]; si += br[p]; end
        endcase
      er[16*q +: 16] = 16'(clampv(sr, ov));
      ei[16*q +: 16] = 16'(clampv(si, ov));
      dr[16*q +: 16] = 16'(xr[q]);
      di[16*q +: 16] = 16'(xi[q]);
    end
    sticky = sticky | ov;
    exp_re[wr_i] = er; exp_im[wr_i] = ei; exp_ov[wr_i] = sticky;
    exp_cyc[wr_i] = cyc; exp_tag[wr_i] = tag;
    wr_i++;
    in_vld = 1'b1; in_grp = 2'(g); in_re = dr; in_im = di;
  endtask

  task automatic garbage();
    in_vld = 1'b0;
    in_grp = 2'($urandom);
    in_re  = {$urandom, $urandom};
    in_im  = {$urandom, $urandom};
  endtask

  // monitor
  logic [63:0] hold_re = '0, hold_im = '0;
  bit last_ov = 0;
  always @(negedge clk) begin
    if (rst) begin
      rd_i = wr_i; last_ov = 0; hold_re = '0; hold_im = '0;
    end else if (out_vld) begin
      if (rd_i >= wr_i)
        chk(1'b0, "R2", "unexpected out_vld actual=1 expected=0");
      else begin
        chk(out_re == exp_re[rd_i] && out_im == exp_im[rd_i], exp_tag[rd_i],
            $sformatf("beat %0d re=%h im=%h expected re=%h im=%h", rd_i,
                      out_re, out_im, exp_re[rd_i], exp_im[rd_i]));
        chk(ovfl == exp_ov[rd_i], "R7",
            $sformatf("beat %0d ovfl=%0d expected %0d", rd_i, ovfl, exp_ov[rd_i]));
        chk(cyc - exp_cyc[rd_i] == 3, "R2",
            $sformatf("beat %0d latency=%0d expected 3", rd_i, cyc - exp_cyc[rd_i]));
        last_ov = exp_ov[rd_i]; hold_re = out_re; hold_im = out_im;
        rd_i++;
      end
    end else begin
      chk(out_re == hold_re && out_im == hold_im && ovfl == last_ov, "R8",
          $sformatf("idle re=%h im=%h ovfl=%0d expected re=%h im=%h ovfl=%0d",
                    out_re, out_im, ovfl, hold_re, hold_im, last_ov));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      garbage();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "R2", "watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int seed;
    int vals [4];
    seed = 7;
    vals[0] = -32768; vals[1] = 32767; vals[2] = 0; vals[3] = 12345;
    repeat (4) @(negedge clk);
    chk(!out_vld && !ovfl && out_re == 0 && out_im == 0, "R1",
        $sformatf("after reset out_vld=%0d ovfl=%0d expected 0 0", out_vld, ovfl));
    rst = 1'b0;

    // small operands, all groups, with idle gaps carrying garbage
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i % 7 == 3) begin
        garbage();
        @(negedge clk);
      end
      for (int p = 0; p < 4; p++) begin
        seed = seed * 1103515245 + 12345;
        xr[p] = longint'((seed >>> 8) & 32'hFFFF) % 8001 - 4000;
        seed = seed * 1103515245 + 12345;
        xi[p] = longint'((seed >>> 8) & 32'hFFFF) % 8001 - 4000;
      end
      push(i % 4, "R3 R5 R9");
    end
    idle(6);
    chk(ovfl == 1'b0, "R7", $sformatf("small operands ovfl=%0d expected 0", ovfl));

    // single active lane shows lane placement and rotations
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin xr[p] = 0; xi[p] = 0; end
    xr[1] = 1000; xi[1] = -2000;
    push(0, "R9");
    idle(5);

    // full-scale sweep over all groups
    for (int g = 0; g < 4; g++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          @(negedge clk);
          for (int p = 0; p < 4; p++) begin
            xr[p] = vals[(a + p) % 4];
            xi[p] = vals[(b + 3 * p) % 4];
          end
          push(g, "R4 R6");
        end
    idle(6);
    chk(ovfl == 1'b1, "R7", $sformatf("after full-scale ovfl=%0d expected 1", ovfl));

    // reset with beats in flight
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin xr[p] = 100 * p; xi[p] = -50 * p; end
      push(1, "R1");
    end
    @(negedge clk);
    garbage();
    rst = 1'b1;
    sticky = 0;
    repeat (2) @(negedge clk);
    chk(!out_vld && !ovfl, "R1",
        $sformatf("mid-flight reset out_vld=%0d ovfl=%0d expected 0 0", out_vld, ovfl));
    rst = 1'b0;
    idle(5);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin xr[p] = 300 - 200 * p; xi[p] = 77 * p; end
    push(3, "R1 R5");
    idle(6);
    chk(rd_i == wr_i, "R2", $sformatf("beats out=%0d expected %0d", rd_i, wr_i));
    summary();
  end
endmodule